// File: doc/BRIEF.md
# Multistage Decimation Filter Chain

The block turns a single-bit delta-sigma modulator stream (nominally 512 kHz, delivered as one `bit_vld_i` strobe per sample) into signed output words. The stream passes through a fixed cascade: a fifth-order CIC decimator, two serial multiply-accumulate FIR decimators and a recursive low-pass stage of selectable order (one to three sections). Each stage offers a small set of decimation ratios. The output can be taken after any stage.

A one-byte configuration word picks the ratios, the IIR order and the output tap. A word that would produce an unsupported output rate is refused and the running setup is kept. FIR and IIR coefficients live in small internal register files. They hold reference values after reset and can be rewritten at any time through a single address/data write port.

With a 512 kHz input, the output word rate runs from 62.5 Hz to 4 kHz. The CIC tap is limited to 4 kHz. The first-FIR tap is limited to 250 Hz through 4 kHz.

Top module: `decim_chain`

## Requirements
- R1: After reset, `dout_o`, `dout_vld_o`, `cfg_err_o` and `fir_ovr_o` are all zero. The active setup is then: IIR tap, CIC ratio 128, FIR1 ratio 4, FIR2 ratio 2, IIR order 1.
- R2: The CIC stage is fifth order. Input bit 1 counts as +1 and bit 0 counts as -1. The ratio is 2^(4+c) for the 2-bit code c, and the output is the comb result shifted right arithmetically by 5*c. Once settled, an all-ones stream gives +2^20, all-zeros gives -2^20, a repeating 1,1,1,0 gives +2^19 and an alternating stream gives 0.
- R3: Each FIR stage has 8 taps. Its output is (sum over k of c[k]*x[n-k]) >>> 15, truncated to 24 bits, and it is produced once per ratio inputs. After reset every tap holds 4096, so a constant input passes through unchanged.
- R4: A coefficient write uses `coef_addr_i[5:4]` as the bank (0 = FIR1, 1 = FIR2, 2 = IIR, 3 = ignored) and `coef_addr_i[3:0]` as the index. Written values take effect from the next computation. A write to bank 3 changes nothing.
- R5: Each IIR section computes y <= y + ((a*(x - y)) >>> 15). The sections are cascaded, the output is taken from section `order`, and a resets to 16384. A positive constant input x settles to x - order, and a negative constant settles to x exactly. With a = 32768 the section passes its input straight through.
- R6: `dout_vld_o` pulses once per R_cic * D1 * D2 input strobes, where only the stages up to the selected tap count.
- R7: Configuration byte layout: [7:6] tap (0 CIC, 1 FIR1, 2 FIR2, 3 IIR), [5:4] IIR order, [3] FIR2 ratio (0 gives 2, 1 gives 4), [2] FIR1 ratio (0 gives 4, 1 gives 16), [1:0] CIC code. A write is refused if the order is 0, if the CIC tap is chosen with a code other than 3, or if the FIR1 tap is chosen with code 0 and FIR1 ratio 4. A refused write pulses `cfg_err_o` for one cycle and leaves the running setup unchanged.
- R8: An accepted write leaves `cfg_err_o` low and applies the new setup at once, restarting every decimation phase.
- R9: A FIR stage raises its sticky bit in `fir_ovr_o` (bit 0 FIR1, bit 1 FIR2) when a new input arrives while its MAC is still running. At the maximum input strobe rate the bits stay low.
- R10: `bit_i` is ignored in cycles where `bit_vld_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Modulator bit |
| bit_vld_i | input | 1 | Modulator bit strobe |
| cfg_wr_i | input | 1 | Configuration write |
| cfg_i | input | 8 | Configuration byte |
| coef_wr_i | input | 1 | Coefficient write |
| coef_addr_i | input | 6 | Coefficient bank and index |
| coef_data_i | input | 18 | Signed coefficient, 15 fraction bits |
| dout_o | output | 24 | Signed output word |
| dout_vld_o | output | 1 | Output word strobe |
| cfg_err_o | output | 1 | Refused configuration pulse |
| fir_ovr_o | output | 2 | Sticky FIR overrun flags |

## Verification
`cfg_err_o` is due in the first cycle after the edge that takes the write, so the bench reads it at the falling edge right after it drops `cfg_wr_i`. Output strobes are due every R_cic*D1*D2 input strobes, which is twice as many clock cycles when the stream has gaps. The bench measures the cycle distance between consecutive `dout_vld_o` pulses on falling edges and compares it with that product. The settled values follow the arithmetic of R2, R3 and R5. The CIC settles within six strobes, the FIRs within eight strobes, and the IIR halving recursion within about 25 strobes, so the bench reads a value only after waiting that many output strobes since the last change of stimulus.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    TAP_CIC  = 2'd0,
    TAP_FIR1 = 2'd1,
    TAP_FIR2 = 2'd2,
    TAP_IIR  = 2'd3
  } tap_e;

  typedef struct packed {
    tap_e       tap;
    logic [1:0] order;
    logic       d2_hi;
    logic       d1_hi;
    logic [1:0] cic_code;
  } chain_cfg_t;

  localparam chain_cfg_t CFG_RST = '{tap: TAP_IIR, order: 2'd1, d2_hi: 1'b0,
                                     d1_hi: 1'b0, cic_code: 2'd3};

  function automatic logic cfg_legal(chain_cfg_t c);
    logic ok;
    ok = (c.order != 2'd0);
    if (c.tap == TAP_CIC && c.cic_code != 2'd3) ok = 1'b0;
    if (c.tap == TAP_FIR1 && c.cic_code == 2'd0 && !c.d1_hi) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/cic_stage.sv
module cic_stage #(
  parameter int N       = 5,
  parameter int CODE_W  = 2,
  parameter int MIN_LOG = 4,
  parameter int DW      = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic                 bit_i,
  input  logic                 vld_i,
  output logic signed [DW-1:0] data_o,
  output logic                 vld_o
);
  localparam int MAX_LOG = MIN_LOG + (1 << CODE_W) - 1;
  localparam int AW      = 2 + N * MAX_LOG;
  localparam int CNT_W   = MAX_LOG;

  logic signed [AW-1:0] integ_q [N];
  logic signed [AW-1:0] dly_q   [N];
  logic signed [AW-1:0] comb    [N+1];
  logic signed [AW-1:0] x_in;
  logic [CNT_W-1:0]     cnt_q, last_cnt;
  logic                 dec;

  assign x_in     = bit_i ? AW'(1) : {AW{1'b1}};
  assign last_cnt = CNT_W'((32'd1 << (MIN_LOG + int'(code_i))) - 32'd1);
  assign dec      = vld_i && (cnt_q == last_cnt);

  assign comb[0] = integ_q[N-1];
  for (genvar i = 0; i < N; i++) begin : g_comb
    assign comb[i+1] = comb[i] - dly_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        integ_q[i] <= '0;
        dly_q[i]   <= '0;
      end
      cnt_q  <= '0;
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= dec && !clr_i;
      if (vld_i) begin
        integ_q[0] <= integ_q[0] + x_in;
        for (int i = 1; i < N; i++) integ_q[i] <= integ_q[i] + integ_q[i-1];
      end
      if (clr_i)      cnt_q <= '0;
      else if (vld_i) cnt_q <= dec ? '0 : cnt_q + 1'b1;
      if (dec) begin
        for (int i = 0; i < N; i++) dly_q[i] <= comb[i];
        data_o <= DW'(comb[N] >>> (N * int'(code_i)));
      end
    end
  end

  a_r2_out_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(vld_i));
endmodule

// File: rtl/fir_stage.sv
module fir_stage #(
  parameter int TAPS   = 8,
  parameter int DW     = 24,
  parameter int CW     = 18,
  parameter int FRAC   = 15,
  parameter int D_LO   = 4,
  parameter int D_HI   = 16,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 dsel_i,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  input  logic                 cwe_i,
  input  logic [ADDR_W-1:0]    cidx_i,
  input  logic signed [CW-1:0] cdata_i,
  output logic signed [DW-1:0] data_o,
  output logic                 vld_o,
  output logic                 ovr_o
);
  localparam int PW    = $clog2(TAPS);
  localparam int AW    = DW + CW + PW + 1;
  localparam int CNT_W = $clog2(D_HI);
  localparam logic signed [CW-1:0] REF_C = CW'((1 << FRAC) / TAPS);

  logic signed [DW-1:0]    smp_q  [TAPS];
  logic signed [CW-1:0]    coef_q [TAPS];
  logic [PW-1:0]           wptr_q, rptr_q, k_q;
  logic [CNT_W-1:0]        dcnt_q;
  logic                    busy_q, start;
  logic signed [AW-1:0]    acc_q, acc_nx;
  logic signed [DW+CW-1:0] prod;

  assign start  = vld_i && !clr_i &&
                  (dcnt_q == CNT_W'((dsel_i ? D_HI : D_LO) - 1));
  assign prod   = smp_q[rptr_q] * coef_q[k_q];
  assign acc_nx = acc_q + AW'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) begin
        smp_q[i]  <= '0;
        coef_q[i] <= REF_C;
      end
      wptr_q <= '0;
      rptr_q <= '0;
      k_q    <= '0;
      dcnt_q <= '0;
      busy_q <= 1'b0;
      acc_q  <= '0;
      data_o <= '0;
      vld_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (cwe_i && (int'(cidx_i) < TAPS)) coef_q[cidx_i[PW-1:0]] <= cdata_i;
      if (vld_i) begin
        smp_q[wptr_q] <= data_i;
        wptr_q        <= wptr_q + 1'b1;
        if (busy_q) ovr_o <= 1'b1;
      end
      if (clr_i)      dcnt_q <= '0;
      else if (vld_i) dcnt_q <= start ? '0 : dcnt_q + 1'b1;
      if (busy_q) begin
        acc_q  <= acc_nx;
        rptr_q <= rptr_q - 1'b1;
        k_q    <= k_q + 1'b1;
        if (k_q == PW'(TAPS - 1)) begin
          busy_q <= 1'b0;
          data_o <= DW'(acc_nx >>> FRAC);
          vld_o  <= 1'b1;
        end
      end
      if (start) begin
        busy_q <= 1'b1;
        k_q    <= '0;
        rptr_q <= wptr_q;
        acc_q  <= '0;
      end
    end
  end

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);
  a_r3_out_after_mac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(busy_q));
endmodule

// File: rtl/iir_stage.sv
module iir_stage #(
  parameter int SECT   = 3,
  parameter int DW     = 24,
  parameter int CW     = 18,
  parameter int FRAC   = 15,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  input  logic [1:0]           order_i,
  input  logic                 cwe_i,
  input  logic [ADDR_W-1:0]    cidx_i,
  input  logic signed [CW-1:0] cdata_i,
  output logic signed [DW-1:0] data_o,
  output logic                 vld_o
);
  localparam int IW = DW + 2;
  localparam int MW = IW + CW;
  localparam int SW = $clog2(SECT);
  localparam logic signed [CW-1:0] REF_A = CW'(1 << (FRAC - 1));

  logic signed [IW-1:0] y_q  [SECT];
  logic signed [CW-1:0] a_q  [SECT];
  logic signed [IW-1:0] s_in [SECT+1];
  logic signed [IW-1:0] y_nx [SECT];
  logic signed [IW-1:0] y_sel;

  assign s_in[0] = IW'(data_i);
  for (genvar i = 0; i < SECT; i++) begin : g_sect
    logic signed [IW-1:0] diff;
    logic signed [MW-1:0] mul;
    assign diff      = s_in[i] - y_q[i];
    assign mul       = diff * a_q[i];
    assign y_nx[i]   = y_q[i] + IW'(mul >>> FRAC);
    assign s_in[i+1] = y_nx[i];
  end

  always_comb begin
    y_sel = y_nx[0];
    for (int j = 1; j < SECT; j++)
      if (int'(order_i) == j + 1) y_sel = y_nx[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SECT; i++) begin
        y_q[i] <= '0;
        a_q[i] <= REF_A;
      end
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (cwe_i && (int'(cidx_i) < SECT)) a_q[cidx_i[SW-1:0]] <= cdata_i;
      if (vld_i) begin
        for (int i = 0; i < SECT; i++) y_q[i] <= y_nx[i];
        data_o <= DW'(y_sel);
      end
    end
  end

  a_r5_out_follows_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(vld_i));
endmodule

// File: rtl/decim_chain.sv
module decim_chain
  import decim_pkg::*;
#(
  parameter int DW       = 24,
  parameter int CW       = 18,
  parameter int FRAC     = 15,
  parameter int CIC_N    = 5,
  parameter int FIR_TAPS = 8,
  parameter int IIR_SECT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              coef_wr_i,
  input  logic [5:0]        coef_addr_i,
  input  logic [CW-1:0]     coef_data_i,
  output logic [DW-1:0]     dout_o,
  output logic              dout_vld_o,
  output logic              cfg_err_o,
  output logic [1:0]        fir_ovr_o
);
  localparam int ADDR_W = 4;

  chain_cfg_t cfg_q, cfg_req;
  logic       accept;
  logic [1:0] bank;
  logic signed [DW-1:0] cic_d, f1_d, f2_d, iir_d, sel_d;
  logic       cic_v, f1_v, f2_v, iir_v, sel_v;

  assign cfg_req = chain_cfg_t'(cfg_i);
  assign accept  = cfg_wr_i && cfg_legal(cfg_req);
  assign bank    = coef_addr_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= CFG_RST;
      cfg_err_o <= 1'b0;
    end else begin
      cfg_err_o <= cfg_wr_i && !cfg_legal(cfg_req);
      if (accept) cfg_q <= cfg_req;
    end
  end

  cic_stage #(.N(CIC_N), .CODE_W(2), .MIN_LOG(4), .DW(DW)) u_cic (
    .clk_i, .rst_ni, .clr_i(accept), .code_i(cfg_q.cic_code),
    .bit_i, .vld_i(bit_vld_i), .data_o(cic_d), .vld_o(cic_v));

  fir_stage #(.TAPS(FIR_TAPS), .DW(DW), .CW(CW), .FRAC(FRAC), .D_LO(4), .D_HI(16),
              .ADDR_W(ADDR_W)) u_fir1 (
    .clk_i, .rst_ni, .clr_i(accept), .dsel_i(cfg_q.d1_hi), .vld_i(cic_v), .data_i(cic_d),
    .cwe_i(coef_wr_i && bank == 2'd0), .cidx_i(coef_addr_i[3:0]), .cdata_i(coef_data_i),
    .data_o(f1_d), .vld_o(f1_v), .ovr_o(fir_ovr_o[0]));

  fir_stage #(.TAPS(FIR_TAPS), .DW(DW), .CW(CW), .FRAC(FRAC), .D_LO(2), .D_HI(4),
              .ADDR_W(ADDR_W)) u_fir2 (
    .clk_i, .rst_ni, .clr_i(accept), .dsel_i(cfg_q.d2_hi), .vld_i(f1_v), .data_i(f1_d),
    .cwe_i(coef_wr_i && bank == 2'd1), .cidx_i(coef_addr_i[3:0]), .cdata_i(coef_data_i),
    .data_o(f2_d), .vld_o(f2_v), .ovr_o(fir_ovr_o[1]));

  iir_stage #(.SECT(IIR_SECT), .DW(DW), .CW(CW), .FRAC(FRAC), .ADDR_W(ADDR_W)) u_iir (
    .clk_i, .rst_ni, .vld_i(f2_v), .data_i(f2_d), .order_i(cfg_q.order),
    .cwe_i(coef_wr_i && bank == 2'd2), .cidx_i(coef_addr_i[3:0]), .cdata_i(coef_data_i),
    .data_o(iir_d), .vld_o(iir_v));

  always_comb begin
    unique case (cfg_q.tap)
      TAP_CIC:  begin sel_v = cic_v; sel_d = cic_d; end
      TAP_FIR1: begin sel_v = f1_v;  sel_d = f1_d;  end
      TAP_FIR2: begin sel_v = f2_v;  sel_d = f2_d;  end
      default:  begin sel_v = iir_v; sel_d = iir_d; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o     <= '0;
      dout_vld_o <= 1'b0;
    end else begin
      dout_vld_o <= sel_v;
      if (sel_v) dout_o <= sel_d;
    end
  end

  a_r7_reject_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $stable(cfg_q));
  a_r7_err_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_wr_i));
  a_r6_out_holds_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_vld_o |-> $stable(dout_o));
endmodule

// File: tb/test_decim_chain.sv
`timescale 1ns/1ps
module test_decim_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_s = 1'b0, bit_vld = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg = '0;
  logic        coef_wr = 1'b0;
  logic [5:0]  coef_addr = '0;
  logic [17:0] coef_data = '0;
  logic [23:0] dout;
  logic        dout_vld, cfg_err;
  logic [1:0]  fir_ovr;

  int checks = 0, fails = 0;
  int mode = 0;
  bit gap = 1'b0;
  int cyc = 0, last_cyc = 0, intv = 0, strobes = 0, last_val = 0;
  localparam int FS = 1 << 20;

  always #2 clk = ~clk;

  decim_chain i_decim_chain (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_s), .bit_vld_i(bit_vld),
    .cfg_wr_i(cfg_wr), .cfg_i(cfg), .coef_wr_i(coef_wr), .coef_addr_i(coef_addr),
    .coef_data_i(coef_data), .dout_o(dout), .dout_vld_o(dout_vld),
    .cfg_err_o(cfg_err), .fir_ovr_o(fir_ovr));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int tap, input int order, input int d2,
                                    input int d1, input int code);
    return {tap[1:0], order[1:0], d2[0], d1[0], code[1:0]};
  endfunction

  task automatic write_cfg(input logic [7:0] v, output logic err);
    @(negedge clk);
    cfg_wr = 1'b1; cfg = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    err = cfg_err;
  endtask

  task automatic write_coef(input int b, input int idx, input int val);
    @(negedge clk);
    coef_wr = 1'b1; coef_addr = {b[1:0], idx[3:0]}; coef_data = val[17:0];
    @(negedge clk);
    coef_wr = 1'b0;
  endtask

  task automatic wait_strobes(input int n);
    int s0;
    s0 = strobes;
    wait (strobes >= s0 + n);
    @(negedge clk);
  endtask

  // stream source
  initial begin
    int n = 0;
    int ph = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bit_vld = 1'b0; bit_s = 1'b0;
      end else if (gap && ph[0]) begin
        bit_vld = 1'b0; bit_s = 1'b0;
        ph++;
      end else begin
        bit_vld = 1'b1;
        case (mode)
          0: bit_s = 1'b1;
          1: bit_s = 1'b0;
          2: bit_s = (n % 4) != 3;
          default: bit_s = n[0];
        endcase
        n++; ph++;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (dout_vld) begin
        last_val = int'($signed(dout));
        intv = cyc - last_cyc;
        last_cyc = cyc;
        strobes++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic e;
    repeat (5) @(negedge clk);
    check("R1 dout", int'(dout), 0);
    check("R1 dout_vld", int'(dout_vld), 0);
    check("R1 cfg_err", int'(cfg_err), 0);
    check("R1 fir_ovr", int'(fir_ovr), 0);
    rst_n = 1'b1;

    // R1/R5: default setup, IIR order 1
    wait_strobes(34);
    check("R1 interval", intv, 1024);
    check("R5 order1 settle", last_val, FS - 1);

    // R8/R2: CIC tap, ratio 128
    write_cfg(mk(0, 1, 0, 0, 3), e);
    check("R8 accept no err", int'(e), 0);
    wait_strobes(8);
    check("R6 cic interval", intv, 128);
    check("R2 ones", last_val, FS);
    mode = 2; wait_strobes(8);
    check("R2 1110", last_val, FS / 2);
    mode = 3; wait_strobes(8);
    check("R2 alternating", last_val, 0);
    mode = 1; wait_strobes(8);
    check("R2 zeros", last_val, -FS);
    mode = 0;

    // R7: refused writes
    write_cfg(mk(0, 1, 0, 0, 0), e);
    check("R7 cic tap ratio16 err", int'(e), 1);
    @(negedge clk);
    check("R7 err one cycle", int'(cfg_err), 0);
    wait_strobes(3);
    check("R7 setup kept", intv, 128);
    write_cfg(mk(1, 1, 0, 0, 0), e);
    check("R7 fir1 tap rate err", int'(e), 1);
    write_cfg(mk(3, 0, 0, 0, 0), e);
    check("R7 order0 err", int'(e), 1);
    wait_strobes(3);
    check("R7 setup kept 2", intv, 128);

    // R3/R6: FIR1 tap
    write_cfg(mk(1, 1, 0, 0, 1), e);
    check("R8 fir1 accept", int'(e), 0);
    wait_strobes(8);
    check("R6 fir1 interval", intv, 128);
    check("R3 fir1 unity", last_val, FS);
    write_cfg(mk(1, 1, 0, 1, 0), e);
    wait_strobes(6);
    check("R6 fir1 d16 interval", intv, 256);

    // R4: FIR1 coefficient rewrite
    write_cfg(mk(1, 1, 0, 0, 1), e);
    write_coef(0, 0, 16384);
    for (int k = 1; k < 8; k++) write_coef(0, k, 0);
    wait_strobes(8);
    check("R4 fir1 half gain", last_val, FS / 2);
    write_coef(3, 0, 5);
    write_coef(3, 1, 77);
    wait_strobes(4);
    check("R4 bank3 ignored", last_val, FS / 2);
    for (int k = 0; k < 8; k++) write_coef(0, k, 4096);

    // R3/R6: FIR2 tap
    write_cfg(mk(2, 1, 1, 0, 0), e);
    wait_strobes(8);
    check("R6 fir2 interval", intv, 256);
    check("R3 fir2 unity", last_val, FS);
    mode = 1; wait_strobes(8);
    check("R3 fir2 zeros", last_val, -FS);
    mode = 0;

    // R5: IIR orders
    write_cfg(mk(3, 2, 0, 0, 0), e);
    wait_strobes(40);
    check("R6 iir interval", intv, 128);
    check("R5 order2 settle", last_val, FS - 2);
    write_cfg(mk(3, 3, 0, 0, 0), e);
    wait_strobes(40);
    check("R5 order3 settle", last_val, FS - 3);
    mode = 1; wait_strobes(40);
    check("R5 negative exact", last_val, -FS);
    mode = 0;
    for (int k = 0; k < 3; k++) write_coef(2, k, 32768);
    wait_strobes(8);
    check("R4 iir passthrough", last_val, FS);

    // R10: gaps with bit_i low while bit_vld_i low
    gap = 1'b1;
    write_cfg(mk(2, 1, 0, 0, 0), e);
    wait_strobes(8);
    check("R10 gap interval", intv, 256);
    check("R10 idle bits ignored", last_val, FS);

    check("R9 no overrun", int'(fir_ovr), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule